// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that retires one instruction on every clock edge. It executes five register-to-register operations (add, subtract, and, or, signed set-less-than), a word load, a word store and a branch taken when two registers are equal. Each cycle the program counter selects a word from a local instruction store. The register file supplies two operands, and the ALU combines them or forms an address. The data store is read or written, and the result is written back on the same edge that advances the program counter.

Both local stores are preloaded through one shared load port. The port is honoured only while reset is asserted, and a select bit chooses the instruction store or the data store. Once reset is released the core runs on its own. A commit trace shows each cycle's program counter, register write-back and store. Software and the testbench observe execution only through this trace.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, `pc_o` is 0 after the first clock edge, `rf_we_o` and `dm_we_o` stay low, and `load_we` writes `load_wdata` into word `load_addr` of the instruction store (`load_to_dmem`=0) or of the data store (`load_to_dmem`=1).
- R2: An instruction that is not a taken branch advances `pc_o` by 4 at the next edge. The instruction store is word indexed by `pc_o[IMEM_AW+1:2]`.
- R3: Opcode 0x00 with bits [10:6]=0 and function 0x20/0x22/0x24/0x25 writes rs+rt, rs-rt, rs&rt or rs|rt to register rd. The fields are rs=[25:21], rt=[20:16] and rd=[15:11].
- R4: Function 0x2A writes 1 to rd when rs is less than rt as signed numbers, otherwise 0.
- R5: Opcode 0x23 writes the data word at byte address rs+sext(imm[15:0]) into register rt. The data store is word indexed by address bits [DMEM_AW+1:2].
- R6: Opcode 0x2B stores rt at byte address rs+sext(imm) and shows it on `dm_we_o`/`dm_addr_o`/`dm_wdata_o`. It writes no register.
- R7: Opcode 0x04 sets the next PC to PC+4+(sext(imm)<<2) when rs equals rt, and to PC+4 otherwise. It writes neither a register nor memory.
- R8: Register 0 reads as zero. A write aimed at it is dropped, and `rf_we_o` stays low.
- R9: An unlisted opcode, or an R-type word with an unlisted function or a non-zero bits [10:6], changes no register or memory and advances the PC by 4.
- R10: Negative 16-bit offsets are sign-extended for loads, stores and branches, including backward branches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; enables the load port |
| load_we | input | 1 | Preload write strobe (honoured only in reset) |
| load_to_dmem | input | 1 | 1 selects the data store, 0 the instruction store |
| load_addr | input | IMEM_AW | Word index for the preload write |
| load_wdata | input | 32 | Preload data word |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| rf_we_o | output | 1 | Register write-back happens at the next edge |
| rf_waddr_o | output | 5 | Destination register |
| rf_wdata_o | output | 32 | Write-back value |
| dm_we_o | output | 1 | Store happens at the next edge |
| dm_addr_o | output | 32 | ALU result / byte address of the access |
| dm_wdata_o | output | 32 | Store data |

## Verification
The bench sweeps every operand pair from a set of extreme values through each ALU function. Signed set-less-than is the most exposed case: a core that compared unsigned would report 0x80000000 as larger than 1. Writes aimed at register 0 and reads from it are both exercised, because a core that let such a write through would then hand back a nonzero r0. Negative offsets and a backward branch are included, since zero-extending the immediate sends addresses and branch targets far away. Illegal opcode and function words are run to catch decoders that fall through to a default write.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BREQ  = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_sel_e;

  typedef struct packed {
    logic       dst_rd;     // 1: rd, 0: rt
    logic       b_imm;      // 1: immediate operand
    logic       wb_mem;     // 1: write back memory data
    logic       reg_wr;
    logic       mem_rd;
    logic       mem_wr;
    logic       is_branch;
    logic [1:0] alu_mode;   // 00 add, 01 sub, 10 by function
  } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0]  opcode,
  input  logic [10:0] fn_field,   // {shamt, funct}
  output ctrl_t       ctrl,
  output alu_sel_e    alu_sel
);
  logic fn_ok;

  always_comb begin
    fn_ok = 1'b0;
    if (fn_field[10:6] == 5'd0) begin
      case (fn_field[5:0])
        FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT: fn_ok = 1'b1;
        default: fn_ok = 1'b0;
      endcase
    end
  end

  always_comb begin
    ctrl = '0;
    case (opcode)
      OPC_REG:   ctrl = '{dst_rd: 1'b1, b_imm: 1'b0, wb_mem: 1'b0, reg_wr: fn_ok,
                          mem_rd: 1'b0, mem_wr: 1'b0, is_branch: 1'b0, alu_mode: 2'b10};
      OPC_LOAD:  ctrl = '{dst_rd: 1'b0, b_imm: 1'b1, wb_mem: 1'b1, reg_wr: 1'b1,
                          mem_rd: 1'b1, mem_wr: 1'b0, is_branch: 1'b0, alu_mode: 2'b00};
      OPC_STORE: ctrl = '{dst_rd: 1'b0, b_imm: 1'b1, wb_mem: 1'b0, reg_wr: 1'b0,
                          mem_rd: 1'b0, mem_wr: 1'b1, is_branch: 1'b0, alu_mode: 2'b00};
      OPC_BREQ:  ctrl = '{dst_rd: 1'b0, b_imm: 1'b0, wb_mem: 1'b0, reg_wr: 1'b0,
                          mem_rd: 1'b0, mem_wr: 1'b0, is_branch: 1'b1, alu_mode: 2'b01};
      default:   ctrl = '0;
    endcase
  end

  always_comb begin
    case (ctrl.alu_mode)
      2'b00:   alu_sel = ALU_ADD;
      2'b01:   alu_sel = ALU_SUB;
      2'b10: begin
        case (fn_field[5:0])
          FN_SUB:  alu_sel = ALU_SUB;
          FN_AND:  alu_sel = ALU_AND;
          FN_OR:   alu_sel = ALU_OR;
          FN_SLT:  alu_sel = ALU_SLT;
          default: alu_sel = ALU_ADD;
        endcase
      end
      default: alu_sel = ALU_SUB;
    endcase
  end

  // R6/R7/R9: at most one kind of state update per instruction
  always_comb begin
    p_one_effect_r9: assert ($onehot0({ctrl.reg_wr, ctrl.mem_wr, ctrl.is_branch}))
      else $error("more than one effect decoded");
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_sel_e     sel,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    case (sel)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

  // R4: set-less-than only ever produces 0 or 1
  always_comb begin
    if (sel == ALU_SLT)
      p_slt_boolean_r4: assert (y[W-1:1] == '0) else $error("slt result not boolean");
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && wa != '0) regs[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_we,
  input  logic               load_to_dmem,
  input  logic [IMEM_AW-1:0] load_addr,
  input  logic [31:0]        load_wdata,
  output logic [31:0]        pc_o,
  output logic               rf_we_o,
  output logic [4:0]         rf_waddr_o,
  output logic [31:0]        rf_wdata_o,
  output logic               dm_we_o,
  output logic [31:0]        dm_addr_o,
  output logic [31:0]        dm_wdata_o
);
  localparam int IWORDS = 1 << IMEM_AW;
  localparam int DWORDS = 1 << DMEM_AW;

  logic [31:0] imem [IWORDS];
  logic [31:0] dmem [DWORDS];

  logic [31:0] pc_q, pc_plus4, br_target, pc_next;
  logic [31:0] instr, simm, rs_val, rt_val, alu_b, alu_y, mem_rdata;
  logic        alu_zero, take_br;
  ctrl_t       ctrl;
  alu_sel_e    alu_sel;

  // instruction store: preload only during reset
  always_ff @(posedge clk) begin
    if (rst && load_we && !load_to_dmem) imem[load_addr] <= load_wdata;
  end
  assign instr = imem[pc_q[IMEM_AW+1:2]];

  sc_ctrl u_ctrl (
    .opcode   (instr[31:26]),
    .fn_field (instr[10:0]),
    .ctrl     (ctrl),
    .alu_sel  (alu_sel)
  );

  assign simm = {{16{instr[15]}}, instr[15:0]};

  sc_regfile #(.W(32), .NREG(32)) u_rf (
    .clk (clk),
    .we  (rf_we_o),
    .wa  (rf_waddr_o),
    .wd  (rf_wdata_o),
    .ra1 (instr[25:21]),
    .ra2 (instr[20:16]),
    .rd1 (rs_val),
    .rd2 (rt_val)
  );

  assign alu_b = ctrl.b_imm ? simm : rt_val;

  sc_alu #(.W(32)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .sel  (alu_sel),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data store: preload in reset, stores when running
  always_ff @(posedge clk) begin
    if (rst) begin
      if (load_we && load_to_dmem) dmem[load_addr[DMEM_AW-1:0]] <= load_wdata;
    end else if (ctrl.mem_wr) begin
      dmem[alu_y[DMEM_AW+1:2]] <= rt_val;
    end
  end
  assign mem_rdata = ctrl.mem_rd ? dmem[alu_y[DMEM_AW+1:2]] : '0;

  // next PC
  assign pc_plus4  = pc_q + 32'd4;
  assign br_target = pc_plus4 + {simm[29:0], 2'b00};
  assign take_br   = ctrl.is_branch && alu_zero;
  assign pc_next   = take_br ? br_target : pc_plus4;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  // commit trace
  assign pc_o       = pc_q;
  assign rf_waddr_o = ctrl.dst_rd ? instr[15:11] : instr[20:16];
  assign rf_wdata_o = ctrl.wb_mem ? mem_rdata : alu_y;
  assign rf_we_o    = !rst && ctrl.reg_wr && (rf_waddr_o != 5'd0);
  assign dm_we_o    = !rst && ctrl.mem_wr;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;

  // R1: nothing is committed while reset is held
  always_comb begin
    if (rst) p_quiet_in_reset_r1: assert (!rf_we_o && !dm_we_o) else $error("commit in reset");
  end

  // R2: sequential flow
  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    !take_br |=> pc_q == $past(pc_q) + 32'd4);

  // R7: taken branch lands on the computed target
  p_branch_target_r7: assert property (@(posedge clk) disable iff (rst)
    take_br |=> pc_q == $past(br_target));

  // R6: a store never writes back a register
  p_store_no_wb_r6: assert property (@(posedge clk) disable iff (rst)
    instr[31:26] == OPC_STORE |-> dm_we_o && !rf_we_o);

  // R7: branches commit no data
  p_branch_no_wr_r7: assert property (@(posedge clk) disable iff (rst)
    instr[31:26] == OPC_BREQ |-> !dm_we_o && !rf_we_o);
endmodule

// File: tb/sc_core_tb.sv
module sc_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_we = 1'b0, load_to_dmem = 1'b0;
  logic [7:0]  load_addr = '0;
  logic [31:0] load_wdata = '0;
  logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic        rf_we_o, dm_we_o;
  logic [4:0]  rf_waddr_o;

  always #5 clk = ~clk;

  sc_core #(.IMEM_AW(8), .DMEM_AW(7)) dut_i (
    .clk(clk), .rst(rst), .load_we(load_we), .load_to_dmem(load_to_dmem),
    .load_addr(load_addr), .load_wdata(load_wdata), .pc_o(pc_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] prog [256];
  int          plen;
  logic [31:0] m_reg [32];
  logic [31:0] m_mem [128];
  logic [31:0] m_pc;
  logic [31:0] vals [8];

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic emit(input logic [31:0] w);
    prog[plen] = w;
    plen++;
  endtask

  task automatic build(input logic [5:0] fn);
    int k;
    plen = 0;
    for (int i = 0; i < 8; i++) emit(enc_i(6'h23, 0, i + 1, 4 * i));
    k = 0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        emit(enc_r(i + 1, j + 1, 9 + (k % 16), fn));
        emit(enc_i(6'h2B, 0, 9 + (k % 16), 4 * (8 + k % 16)));
        k++;
      end
    emit(enc_r(2, 2, 0, 6'h20));          // write to r0 (R8)
    emit(enc_r(0, 2, 25, 6'h20));         // r0 reads zero (R8)
    emit(enc_i(6'h23, 6, 26, -4));        // negative load offset (R10)
    emit(enc_i(6'h2B, 6, 7, -8));         // negative store offset (R10)
    emit(enc_i(6'h23, 0, 27, 0));         // read back stored word
    emit(enc_i(6'h23, 0, 28, 32));        // read back a result word
    emit(enc_i(6'h04, 2, 3, 5));          // not taken
    emit(enc_i(6'h04, 0, 0, 2));          // a -> d
    emit(enc_i(6'h04, 0, 0, 2));          // b -> e
    emit(32'hFC00_0000);                  // c: skipped
    emit(enc_i(6'h04, 0, 0, -3));         // d -> b (backward, R10)
    emit(32'hFFFF_FFFF);                  // e: unknown opcode (R9)
    emit(enc_r(2, 2, 29, 6'h3F));         // unknown function (R9)
    emit({6'h00, 5'd2, 5'd2, 5'd30, 5'd1, 6'h20}); // non-zero shamt (R9)
    emit(enc_i(6'h04, 0, 0, -1));         // halt loop
  endtask

  // reference step from the requirements; checks the trace, then updates the model
  task automatic step_check();
    logic [31:0] ins, a, b, sx, res, nxt, addr;
    logic [5:0]  op, fn;
    logic        ok_fn, wr, st;
    logic [4:0]  wa;
    string       tag;
    ins = prog[m_pc[9:2]];
    op = ins[31:26]; fn = ins[5:0];
    a = (ins[25:21] == 0) ? 32'd0 : m_reg[ins[25:21]];
    b = (ins[20:16] == 0) ? 32'd0 : m_reg[ins[20:16]];
    sx = {{16{ins[15]}}, ins[15:0]};
    nxt = m_pc + 4; wr = 0; st = 0; wa = 0; res = 0; addr = a + sx;
    tag = "R9";
    ok_fn = (ins[10:6] == 0) && (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 ||
                                 fn == 6'h25 || fn == 6'h2A);
    if (op == 6'h00 && ok_fn) begin
      case (fn)
        6'h20: res = a + b;
        6'h22: res = a - b;
        6'h24: res = a & b;
        6'h25: res = a | b;
        default: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      endcase
      wa = ins[15:11]; wr = (wa != 0);
      tag = (fn == 6'h2A) ? "R4" : ((wa == 0 || ins[25:21] == 0) ? "R8" : "R3");
    end else if (op == 6'h23) begin
      res = m_mem[addr[8:2]]; wa = ins[20:16]; wr = (wa != 0);
      tag = sx[31] ? "R10" : "R5";
    end else if (op == 6'h2B) begin
      st = 1; tag = sx[31] ? "R10" : "R6";
    end else if (op == 6'h04) begin
      if (a == b) nxt = m_pc + 4 + {sx[29:0], 2'b00};
      tag = sx[31] ? "R10" : "R7";
    end
    chk((op == 6'h04) ? tag : "R2", "pc", pc_o, m_pc);
    chk(tag, "rf_we", 32'(rf_we_o), 32'(wr));
    if (wr) begin
      chk(tag, "rf_waddr", 32'(rf_waddr_o), 32'(wa));
      chk(tag, "rf_wdata", rf_wdata_o, res);
    end
    chk(tag, "dm_we", 32'(dm_we_o), 32'(st));
    if (st) begin
      chk(tag, "dm_addr", dm_addr_o, addr);
      chk(tag, "dm_wdata", dm_wdata_o, b);
    end
    if (wr) m_reg[wa] = res;
    if (st) m_mem[addr[8:2]] = b;
    m_pc = nxt;
  endtask

  task automatic run_prog(input logic [5:0] fn);
    build(fn);
    @(negedge clk);
    rst = 1;
    load_we = 1;
    for (int i = 0; i < plen; i++) begin
      load_to_dmem = 0; load_addr = 8'(i); load_wdata = prog[i];
      @(negedge clk);
    end
    for (int i = 0; i < 8; i++) begin
      load_to_dmem = 1; load_addr = 8'(i); load_wdata = vals[i];
      m_mem[i] = vals[i];
      @(negedge clk);
    end
    load_we = 0;
    #1;
    chk("R1", "pc in reset", pc_o, 32'd0);
    chk("R1", "rf_we in reset", 32'(rf_we_o), 32'd0);
    chk("R1", "dm_we in reset", 32'(dm_we_o), 32'd0);
    @(negedge clk);
    rst = 0;
    m_pc = 0;
    #1;
    for (int c = 0; c < plen + 8; c++) begin
      step_check();
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    vals = '{32'd0, 32'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
             32'h8000_0000, 32'd8, 32'hFFFF_FFF9, 32'h0000_1234};
    for (int i = 0; i < 32; i++) m_reg[i] = 0;
    for (int i = 0; i < 128; i++) m_mem[i] = 0;
    repeat (2) @(negedge clk);
    run_prog(6'h20);   // R3 add
    run_prog(6'h22);   // R3 sub
    run_prog(6'h24);   // R3 and
    run_prog(6'h25);   // R3 or
    run_prog(6'h2A);   // R4 signed compare
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule